// File: doc/BRIEF.md
# MII Dual-Clock Frame Loopback Bridge

This block accepts nibble-wide frames on a receive port that is timed by its own receive clock. It sends the same frames out on a transmit port that is timed by a separate transmit clock. The two clocks share a nominal rate, 25 MHz for 100 Mbps links, but have no phase relation. Nibbles cross from one domain to the other through an asynchronous FIFO. Its pointers are Gray-coded and pass through two-flop synchronizers.

Every stored entry is five bits wide: a four-bit nibble and a flag that marks the final nibble of a frame. The flag lets frame boundaries survive the crossing. A second Gray-coded counter of completed frames also crosses into the transmit domain. The transmit side uses it to see that a whole frame is waiting.

A mode input selects when transmission starts:
- **Cut-through:** sending begins once a threshold number of nibbles is buffered, or once a shorter frame is complete.
- **Store-and-forward:** sending waits until a whole frame is held.

Overflow on the write side and underrun on the read side are reported through sticky flags.

Top module: `mii_loop_bridge`

## Requirements
- R1: While and after reset, tx_en_o, tx_data_o, overflow_o and underrun_o are all 0.
- R2: The nibbles of a frame leave on tx_data_o in the order they arrived on rx_data_i, unchanged, with rx_data_i bit k appearing on tx_data_o bit k.
- R3: A nibble that must be stored while the FIFO already holds 2**ADDR_W (default 4096) entries is dropped, and overflow_o goes to 1. overflow_o stays 1 until reset. A frame whose final nibble was dropped is never sent.
- R4: Each receive frame is one interval of rx_dv_i high. Each receive frame produces exactly one interval of tx_en_o high of the same length. Between two frames, tx_en_o is low for at least one transmit clock, even when the receive frames are separated by a single idle receive clock.
- R5: With mode_sf_i = 0 (cut-through), transmission starts after at least THRESH (default 5) nibbles of the frame are buffered. It does not wait for the end of a long frame.
- R6: With mode_sf_i = 1 (store-and-forward), tx_en_o stays low until rx_dv_i has fallen and the complete frame is buffered.
- R7: In cut-through mode, if the FIFO runs empty inside a frame, three things happen:
  - underrun_o goes to 1 and stays 1 until reset.
  - tx_en_o drops.
  - The rest of that frame is discarded.

  The following frame is sent intact. underrun_o never rises in store-and-forward mode.
- R8: A store-and-forward frame of exactly 2**ADDR_W nibbles is forwarded completely, without overflow.
- R9: The write pointer seen by the transmit domain changes by at most one bit per receive clock (Gray code). This keeps long frames intact across the clock crossing.
- R10: Frames shorter than THRESH, down to a single nibble, are forwarded in cut-through mode once complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk_i | input | 1 | Receive clock |
| tx_clk_i | input | 1 | Transmit clock, unrelated to rx_clk_i |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| mode_sf_i | input | 1 | 1 = store-and-forward, 0 = cut-through; change only while idle |
| rx_data_i | input | 4 | Receive nibble |
| rx_dv_i | input | 1 | Receive data valid, high for the length of a frame |
| tx_data_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit enable |
| overflow_o | output | 1 | Sticky FIFO overflow flag (receive domain) |
| underrun_o | output | 1 | Sticky mid-frame underrun flag (transmit domain) |

## Verification
**Latency chain.** A received nibble passes through the following before the start policy can see it:
- an input register,
- a one-nibble holding stage that decides the end-of-frame flag,
- the FIFO write,
- two transmit-clock synchronizer stages.

After that, one state-change cycle and one output register follow. The first transmitted nibble therefore lags by a few cycles of each clock.

**Sampling method.** The clocks are unrelated, so the bench never predicts an exact cycle. It samples tx_en_o and tx_data_o on the falling transmit edge. It collects whole frames and compares them ten transmit cycles after the expected number of tx_en_o falls.

**Start-policy checks.** Start conditions are checked by relation, not by cycle:
- The count of nibbles already driven when tx_en_o first rises.
- The time of rx_dv_i falling against the first tx_en_o rise.

**Flag checks.** Sticky flags are read twenty or more transmit cycles after the last stimulus.

// File: rtl/mlb_pkg.sv
`timescale 1ns/1ps
package mlb_pkg;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic             last;
    logic [NIB_W-1:0] nib;
  } ent_t;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_DRAIN} tx_st_e;
endpackage

// File: rtl/mlb_sync.sv
`timescale 1ns/1ps
module mlb_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/mlb_store.sv
`timescale 1ns/1ps
module mlb_store import mlb_pkg::*; #(
  parameter int ADDR_W = 12
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  ent_t              wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output ent_t              rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  ent_t mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read is combinational; the reader only addresses entries its synced pointer shows as written
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mlb_rx_front.sv
`timescale 1ns/1ps
module mlb_rx_front import mlb_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int FRM_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  rx_data_i,
  input  logic              rx_dv_i,
  input  logic [ADDR_W:0]   rptr_gray_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output ent_t              wdata_o,
  output logic [ADDR_W:0]   wptr_gray_o,
  output logic [FRM_W-1:0]  frm_gray_o,
  output logic              wr_req_o,
  output logic              full_o,
  output logic              overflow_o
);
  localparam int PW = ADDR_W + 1;

  logic [NIB_W-1:0] d_q, pend_nib_q;
  logic             dv_q, pend_vld_q;
  logic [PW-1:0]    wbin_q, wbin_nx;
  logic [FRM_W-1:0] fbin_q, fbin_nx;

  // register pins before use
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q  <= '0;
      dv_q <= 1'b0;
    end else begin
      d_q  <= rx_data_i;
      dv_q <= rx_dv_i;
    end
  end

  // one-nibble hold: the entry is written when the next dv sample tells if it was the last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_nib_q <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      pend_vld_q <= dv_q;
      if (dv_q) pend_nib_q <= d_q;
    end
  end

  assign wr_req_o = pend_vld_q;
  assign full_o   = (wptr_gray_o == {~rptr_gray_i[PW-1:PW-2], rptr_gray_i[PW-3:0]});
  assign we_o     = wr_req_o & ~full_o;
  assign waddr_o  = wbin_q[ADDR_W-1:0];

  always_comb begin
    wdata_o.nib  = pend_nib_q;
    wdata_o.last = ~dv_q;
    wbin_nx      = wbin_q + PW'(we_o);
    fbin_nx      = fbin_q + FRM_W'(we_o & ~dv_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q      <= '0;
      wptr_gray_o <= '0;
      fbin_q      <= '0;
      frm_gray_o  <= '0;
      overflow_o  <= 1'b0;
    end else begin
      wbin_q      <= wbin_nx;
      wptr_gray_o <= wbin_nx ^ (wbin_nx >> 1);
      fbin_q      <= fbin_nx;
      frm_gray_o  <= fbin_nx ^ (fbin_nx >> 1);
      if (wr_req_o && full_o) overflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mlb_tx_ctrl.sv
`timescale 1ns/1ps
module mlb_tx_ctrl import mlb_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int FRM_W  = 4,
  parameter int THRESH = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_sf_i,
  input  logic [ADDR_W:0]   wptr_gray_i,
  input  logic [FRM_W-1:0]  frm_gray_i,
  input  ent_t              rd_ent_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rptr_gray_o,
  output logic [NIB_W-1:0]  tx_data_o,
  output logic              tx_en_o,
  output logic              underrun_o,
  output logic              pop_o,
  output logic              pop_last_o
);
  localparam int            PW  = ADDR_W + 1;
  localparam logic [PW-1:0] THR = PW'(THRESH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  tx_st_e           st_q;
  logic [PW-1:0]    rbin_q, rbin_nx, wbin, fill;
  logic [FRM_W-1:0] frd_q;
  logic             empty, frm_avail, start;

  always_comb begin
    wbin       = g2b(wptr_gray_i);
    fill       = wbin - rbin_q;
    empty      = (fill == '0);
    frm_avail  = (frm_gray_i != (frd_q ^ (frd_q >> 1)));
    start      = !empty && (frm_avail || (!mode_sf_i && fill >= THR));
    pop_o      = ((st_q == TX_SEND) || (st_q == TX_DRAIN)) && !empty;
    pop_last_o = pop_o & rd_ent_i.last;
    rbin_nx    = rbin_q + PW'(pop_o);
  end

  assign raddr_o = rbin_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q      <= '0;
      rptr_gray_o <= '0;
      frd_q       <= '0;
    end else begin
      rbin_q      <= rbin_nx;
      rptr_gray_o <= rbin_nx ^ (rbin_nx >> 1);
      if (pop_last_o) frd_q <= frd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= TX_IDLE;
      tx_en_o    <= 1'b0;
      tx_data_o  <= '0;
      underrun_o <= 1'b0;
    end else begin
      unique case (st_q)
        TX_IDLE: begin
          tx_en_o   <= 1'b0;
          tx_data_o <= '0;
          if (start) st_q <= TX_SEND;
        end
        TX_SEND: begin
          if (!empty) begin
            tx_en_o   <= 1'b1;
            tx_data_o <= rd_ent_i.nib;
            if (rd_ent_i.last) st_q <= TX_IDLE;
          end else if (!mode_sf_i) begin
            // starved mid-frame: cut the frame, drop its tail
            tx_en_o    <= 1'b0;
            tx_data_o  <= '0;
            underrun_o <= 1'b1;
            st_q       <= TX_DRAIN;
          end
        end
        TX_DRAIN: begin
          tx_en_o   <= 1'b0;
          tx_data_o <= '0;
          if (pop_last_o) st_q <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mii_loop_bridge.sv
`timescale 1ns/1ps
module mii_loop_bridge import mlb_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int THRESH = 5,
  parameter int FRM_W  = 4
) (
  input  logic             rx_clk_i,
  input  logic             tx_clk_i,
  input  logic             rst_ni,
  input  logic             mode_sf_i,
  input  logic [NIB_W-1:0] rx_data_i,
  input  logic             rx_dv_i,
  output logic [NIB_W-1:0] tx_data_o,
  output logic             tx_en_o,
  output logic             overflow_o,
  output logic             underrun_o
);
  localparam int PW = ADDR_W + 1;
  localparam int XW = PW + FRM_W;

  logic              wr_req, wr_full, mem_we;
  logic [ADDR_W-1:0] waddr, raddr;
  ent_t              wdata, rdata;
  logic [PW-1:0]     wptr_gray, rptr_gray, rptr_gray_rx, wptr_gray_tx;
  logic [FRM_W-1:0]  frm_gray, frm_gray_tx;
  logic [XW-1:0]     xs_tx;
  logic              pop, pop_last;

  mlb_rx_front #(.ADDR_W(ADDR_W), .FRM_W(FRM_W)) u_rx (
    .clk_i       (rx_clk_i),
    .rst_ni      (rst_ni),
    .rx_data_i   (rx_data_i),
    .rx_dv_i     (rx_dv_i),
    .rptr_gray_i (rptr_gray_rx),
    .we_o        (mem_we),
    .waddr_o     (waddr),
    .wdata_o     (wdata),
    .wptr_gray_o (wptr_gray),
    .frm_gray_o  (frm_gray),
    .wr_req_o    (wr_req),
    .full_o      (wr_full),
    .overflow_o  (overflow_o)
  );

  mlb_sync #(.W(PW)) u_sync_r2w (
    .clk_i  (rx_clk_i),
    .rst_ni (rst_ni),
    .d_i    (rptr_gray),
    .q_o    (rptr_gray_rx)
  );

  mlb_sync #(.W(XW)) u_sync_w2r (
    .clk_i  (tx_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({frm_gray, wptr_gray}),
    .q_o    (xs_tx)
  );

  assign wptr_gray_tx = xs_tx[PW-1:0];
  assign frm_gray_tx  = xs_tx[XW-1:PW];

  mlb_store #(.ADDR_W(ADDR_W)) u_mem (
    .wclk_i  (rx_clk_i),
    .we_i    (mem_we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  mlb_tx_ctrl #(.ADDR_W(ADDR_W), .FRM_W(FRM_W), .THRESH(THRESH)) u_tx (
    .clk_i       (tx_clk_i),
    .rst_ni      (rst_ni),
    .mode_sf_i   (mode_sf_i),
    .wptr_gray_i (wptr_gray_tx),
    .frm_gray_i  (frm_gray_tx),
    .rd_ent_i    (rdata),
    .raddr_o     (raddr),
    .rptr_gray_o (rptr_gray),
    .tx_data_o   (tx_data_o),
    .tx_en_o     (tx_en_o),
    .underrun_o  (underrun_o),
    .pop_o       (pop),
    .pop_last_o  (pop_last)
  );
endmodule

// File: rtl/mlb_checker.sv
`timescale 1ns/1ps
module mlb_checker #(
  parameter int PW = 13
) (
  input logic          rx_clk_i,
  input logic          tx_clk_i,
  input logic          rst_ni,
  input logic          mode_sf_i,
  input logic          tx_en_o,
  input logic          overflow_o,
  input logic          underrun_o,
  input logic          wr_req,
  input logic          wr_full,
  input logic          mem_we,
  input logic [PW-1:0] wptr_gray,
  input logic          pop_last
);
  p_gray_step_r9: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  p_drop_when_full_r3: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    (wr_req && wr_full) |-> !mem_we);

  p_ovf_sticky_r3: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_udr_sticky_r7: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  p_udr_ct_only_r7: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> !$past(mode_sf_i));

  p_gap_after_last_r4: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    pop_last |=> ##1 !tx_en_o);
endmodule

bind mii_loop_bridge mlb_checker #(.PW(ADDR_W + 1)) u_chk (
  .rx_clk_i   (rx_clk_i),
  .tx_clk_i   (tx_clk_i),
  .rst_ni     (rst_ni),
  .mode_sf_i  (mode_sf_i),
  .tx_en_o    (tx_en_o),
  .overflow_o (overflow_o),
  .underrun_o (underrun_o),
  .wr_req     (wr_req),
  .wr_full    (wr_full),
  .mem_we     (mem_we),
  .wptr_gray  (wptr_gray),
  .pop_last   (pop_last)
);

// File: tb/sim_mii_loop_bridge.sv
`timescale 1ns/1ps
module sim_mii_loop_bridge;
  localparam int THRESH = 5;
  localparam int DEPTH  = 4096;
  localparam int NV     = 7;
  // {sf, len[15:0], seed[3:0], step[3:0]}
  localparam logic [24:0] VEC [0:NV-1] = '{
    {1'b0, 16'd1,    4'h3, 4'h1},
    {1'b0, 16'd3,    4'hA, 4'h5},
    {1'b0, 16'd5,    4'h0, 4'h1},
    {1'b1, 16'd6,    4'hF, 4'h3},
    {1'b0, 16'd64,   4'h7, 4'h9},
    {1'b1, 16'd120,  4'h2, 4'h7},
    {1'b0, 16'd2800, 4'h1, 4'h1}
  };

  logic       rx_clk = 1'b0, tx_clk = 1'b0, rst_n = 1'b0, mode_sf = 1'b0;
  logic [3:0] rx_data = '0;
  logic       rx_dv = 1'b0;
  logic [3:0] tx_data;
  logic       tx_en, ovf, udr;
  int         rx_half = 9;

  mii_loop_bridge #(.THRESH(THRESH)) u0 (
    .rx_clk_i(rx_clk), .tx_clk_i(tx_clk), .rst_ni(rst_n), .mode_sf_i(mode_sf),
    .rx_data_i(rx_data), .rx_dv_i(rx_dv), .tx_data_o(tx_data), .tx_en_o(tx_en),
    .overflow_o(ovf), .underrun_o(udr)
  );

  always #10 tx_clk = ~tx_clk;  // 50 MHz
  always begin #(rx_half); rx_clk = ~rx_clk; end

  int      n_chk = 0, n_fail = 0;
  bit      done = 0;
  logic [3:0] cap [0:8191];
  int      cap_n = 0, frm_n = 0, rx_sent = 0, first_en_sent = 0;
  bit      prev_en = 0, got_en = 0;
  longint  first_en_time = 0, dv_fall_time = 0;

  always @(negedge tx_clk) begin
    if (tx_en) begin
      if (cap_n < 8192) cap[cap_n] = tx_data;
      cap_n++;
      if (!prev_en && !got_en) begin
        got_en = 1; first_en_time = $time; first_en_sent = rx_sent;
      end
    end
    if (prev_en && !tx_en) frm_n++;
    prev_en = tx_en;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] enib(input logic [3:0] s, input logic [3:0] st, input int i);
    return 4'(int'(s) + i * int'(st));
  endfunction

  task automatic clear_mon();
    cap_n = 0; frm_n = 0; rx_sent = 0; got_en = 0; first_en_time = 0; first_en_sent = 0;
  endtask

  task automatic send_frame(input int len, input logic [3:0] s, input logic [3:0] st);
    for (int i = 0; i < len; i++) begin
      @(negedge rx_clk); rx_dv = 1'b1; rx_data = enib(s, st, i); rx_sent++;
    end
    @(negedge rx_clk); rx_dv = 1'b0; rx_data = '0; dv_fall_time = $time;
  endtask

  task automatic wait_frames(input int n, input int maxc);
    for (int c = 0; c < maxc && frm_n < n; c++) @(posedge tx_clk);
    repeat (10) @(posedge tx_clk);
  endtask

  function automatic int mism(input int base, input int len, input logic [3:0] s, input logic [3:0] st);
    int m = 0;
    for (int i = 0; i < len; i++) if (cap[base + i] !== enib(s, st, i)) m++;
    return m;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; rx_dv = 1'b0; rx_data = '0;
    repeat (4) @(posedge tx_clk);
    #3 rst_n = 1'b1;
    repeat (4) @(posedge tx_clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic       vsf;
    int         vlen, m;
    logic [3:0] vs, vst;

    // R1 reset state
    repeat (3) @(negedge tx_clk);
    chk(!tx_en && tx_data == 0 && !ovf && !udr, "R1 in reset", {tx_en, tx_data, ovf, udr}, 0);
    do_reset();
    @(negedge tx_clk);
    chk(!tx_en && tx_data == 0, "R1 tx after reset", {tx_en, tx_data}, 0);
    chk(!ovf && !udr, "R1 flags after reset", {ovf, udr}, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      vsf  = VEC[v][24];
      vlen = int'(VEC[v][23:8]);
      vs   = VEC[v][7:4];
      vst  = VEC[v][3:0];
      @(posedge tx_clk);
      mode_sf = vsf;
      clear_mon();
      send_frame(vlen, vs, vst);
      wait_frames(1, 12000);
      chk(frm_n == 1 && cap_n == vlen, "R4 frame length", cap_n, vlen);
      m = mism(0, vlen, vs, vst);
      chk(m == 0, "R2 content", m, 0);
      if (vsf)
        chk(got_en && first_en_time > dv_fall_time, "R6 start after dv fall", first_en_time, dv_fall_time);
      else if (vlen >= THRESH)
        chk(first_en_sent >= THRESH, "R5 start threshold", first_en_sent, THRESH);
      else
        chk(cap_n == vlen, "R10 short frame", cap_n, vlen);
      if (!vsf && vlen > 100) begin
        chk(first_en_sent < vlen, "R5 cut-through before end", first_en_sent, vlen);
        chk(m == 0 && !ovf, "R9 long crossing intact", m, 0);
      end
    end

    // R4 back-to-back frames, one idle rx cycle apart
    @(posedge tx_clk);
    mode_sf = 1'b0;
    clear_mon();
    send_frame(10, 4'h4, 4'h3);
    send_frame(12, 4'h9, 4'hB);
    wait_frames(2, 4000);
    chk(frm_n == 2, "R4 two tx frames", frm_n, 2);
    chk(cap_n == 22, "R4 total nibbles", cap_n, 22);
    m = mism(0, 10, 4'h4, 4'h3) + mism(10, 12, 4'h9, 4'hB);
    chk(m == 0, "R2 back-to-back content", m, 0);

    // R8 full-depth store-and-forward frame
    @(posedge tx_clk);
    mode_sf = 1'b1;
    clear_mon();
    send_frame(DEPTH, 4'h6, 4'h5);
    wait_frames(1, 20000);
    chk(!ovf, "R8 no overflow at depth", ovf, 0);
    chk(cap_n == DEPTH, "R8 full frame length", cap_n, DEPTH);
    m = mism(0, DEPTH, 4'h6, 4'h5);
    chk(m == 0, "R8 full frame content", m, 0);

    // R7 underrun: slow receive clock in cut-through
    @(posedge tx_clk);
    mode_sf = 1'b0;
    rx_half = 30;
    clear_mon();
    send_frame(40, 4'h2, 4'h1);
    repeat (200) @(posedge tx_clk);
    chk(udr == 1'b1, "R7 underrun flag", udr, 1);
    chk(frm_n == 1 && cap_n > 0 && cap_n < 40, "R7 frame cut", cap_n, 40);
    m = mism(0, cap_n, 4'h2, 4'h1);
    chk(m == 0, "R7 prefix content", m, 0);
    rx_half = 9;
    @(posedge tx_clk);
    clear_mon();
    send_frame(20, 4'hC, 4'h7);
    wait_frames(1, 4000);
    m = mism(0, 20, 4'hC, 4'h7);
    chk(frm_n == 1 && cap_n == 20 && m == 0, "R7 next frame intact", cap_n, 20);
    chk(udr == 1'b1, "R7 underrun sticky", udr, 1);

    // R3 overflow: store-and-forward frame larger than the FIFO
    do_reset();
    chk(!udr && !ovf, "R1 flags cleared by reset", {ovf, udr}, 0);
    @(posedge tx_clk);
    mode_sf = 1'b1;
    clear_mon();
    send_frame(DEPTH + 104, 4'h1, 4'h3);
    repeat (20) @(posedge tx_clk);
    chk(ovf == 1'b1, "R3 overflow flag", ovf, 1);
    chk(cap_n == 0, "R3 truncated frame not sent", cap_n, 0);
    repeat (100) @(posedge tx_clk);
    chk(ovf == 1'b1, "R3 overflow sticky", ovf, 1);
    do_reset();
    @(negedge tx_clk);
    chk(!ovf && !tx_en, "R3 cleared only by reset", ovf, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule